// File: doc/BRIEF.md
# Root Port Error Collector

This block collects error messages that reach a root port and records them in three software-visible registers: a root error status register, a root error command register and a source identification register. Every incoming message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identity. The block sets received flags and "multiple" flags. It keeps the identity of the first correctable and of the first uncorrectable source, and it notes whether the first uncorrectable error was fatal.

The command register holds one enable per severity class. Each enabled class that has a received condition asks for an interrupt. If neither message-signaled mode is strapped on, the interrupt is a level line. In a message-signaled mode it is a one-cycle request that carries the interrupt message number. That number comes from a device-specific input and appears read-only in the top bits of the status register. A message request is raised only when the set of enabled received conditions goes from empty to non-empty. That change can come from an incoming message or from a command write.

Top module: `root_err_collector`

## Requirements
- R1: After reset, status flags, command register, source identification register, level interrupt and request output are all zero.
- R2: A message with severity code 0 (correctable) sets status bit 0. If bit 0 was already set, it sets bit 1 (multiple correctable) and leaves the source register alone. Otherwise it stores the source identity in source register bits 15:0. Severity code 3 is not a message and changes nothing.
- R3: Severity code 1 (non-fatal) sets status bit 5. Severity code 2 (fatal) sets status bit 6, and also sets bit 4 (first fatal) when bit 2 was clear before the message.
- R4: Any message of code 1 or 2 sets status bit 2 (uncorrectable received). If bit 2 was already set, it sets bit 3 (multiple uncorrectable). Otherwise it stores the source identity in source register bits 31:16.
- R5: A register write with address 1 clears every status flag in bits 6:0 whose data bit is 1. The clear is applied before a message in the same cycle, so the message's flags and its first-source capture win.
- R6: Status bits 31:27 show the interrupt message number input as it was one cycle earlier. Writes do not change them.
- R7: A register write with address 0 loads data bits 2:0 into the command register: bit 0 enables correctable, bit 1 enables non-fatal, bit 2 enables fatal.
- R8: A message requests an interrupt only if the enable for its own severity is set and no enabled received condition was true just before it. The received conditions are bit 0 paired with enable 0, bit 5 with enable 1, and bit 6 with enable 2.
- R9: In level mode (both message-signaled straps low), any register write sets the level line to the OR of the enabled received conditions after the write. A requesting message with no write drives the line high, and otherwise the line holds.
- R10: In a message-signaled mode, a command write raises a request when no enabled received condition was true under the old command and at least one is true under the new one.
- R11: The extended message-signaled strap takes priority over the plain one, and either takes priority over the level line. A request is a one-cycle pulse one cycle after its cause. It carries the message number that status bits 31:27 show at that moment and a flag telling which message-signaled mode is in use. The level line holds while a message-signaled mode is strapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal |
| msg_src | input | 16 | Requester identity of the message |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | 0 command register, 1 status register (write 1 to clear) |
| reg_wr_data | input | 32 | Write data |
| irq_vec_in | input | 5 | Device-specific interrupt message number |
| msi_en | input | 1 | Plain message-signaled interrupt strap |
| msix_en | input | 1 | Extended message-signaled interrupt strap |
| root_status | output | 32 | Root error status register |
| root_cmd | output | 3 | Root error command register |
| root_src_id | output | 32 | First uncorrectable source in 31:16, first correctable in 15:0 |
| intx_level | output | 1 | Level interrupt line |
| irq_req | output | 1 | One-cycle message-signaled interrupt request |
| irq_req_msix | output | 1 | Request uses the extended mode |
| irq_req_vec | output | 5 | Message number carried by the request |

## Verification
The bench builds the block with its default parameters: 16-bit source identities, a 5-bit message number and a 32-bit register word. With this 5-bit number, bits 31:27 stand exactly where R6 places them. At these widths every source capture and every message number is visible whole on the ports. The random traffic switches between the level and message-signaled straps, so the edge rule for requests and the level recomputation on writes both meet clears and messages that land in the same cycle.

// File: rtl/rec_pkg.sv
package rec_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_NONE     = 2'd3
  } sev_e;

  // Bit order is the register layout: fatal at 6 down to correctable at 0.
  typedef struct packed {
    logic fatal;
    logic nonfatal;
    logic first_fatal;
    logic multi_unc;
    logic unc;
    logic multi_cor;
    logic cor;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
  localparam int CMD_W  = 3;

  // Received conditions lined up with the command enables.
  function automatic logic [CMD_W-1:0] cond_map(input flags_t f);
    return {f.fatal, f.nonfatal, f.cor};
  endfunction

  function automatic logic [CMD_W-1:0] sev_onehot(input sev_e s);
    case (s)
      SEV_COR:      return 3'b001;
      SEV_NONFATAL: return 3'b010;
      SEV_FATAL:    return 3'b100;
      default:      return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/rec_rst_sync.sv
module rec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rec_status.sv
module rec_status
  import rec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  sev_e             msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  flags_t           clr_mask,
  input  logic [VEC_W-1:0] vec_in,
  output flags_t           flags_q,
  output flags_t           flags_pre,
  output flags_t           flags_d,
  output logic [SRC_W-1:0] src_cor_q,
  output logic [SRC_W-1:0] src_unc_q,
  output logic [VEC_W-1:0] vec_q
);
  logic             is_cor, is_nf, is_fat, is_unc;
  logic             flags_en, cor_cap, unc_cap;
  logic [SRC_W-1:0] src_cor_d, src_unc_d;

  always_comb begin
    is_cor = msg_valid && (msg_sev == SEV_COR);
    is_nf  = msg_valid && (msg_sev == SEV_NONFATAL);
    is_fat = msg_valid && (msg_sev == SEV_FATAL);
    is_unc = is_nf || is_fat;

    flags_pre = flags_t'(flags_q & ~clr_mask);
    flags_d   = flags_pre;
    cor_cap   = 1'b0;
    unc_cap   = 1'b0;

    if (is_cor) begin
      if (flags_pre.cor) flags_d.multi_cor = 1'b1;
      else               cor_cap = 1'b1;
      flags_d.cor = 1'b1;
    end
    if (is_nf) flags_d.nonfatal = 1'b1;
    if (is_fat) begin
      if (!flags_pre.unc) flags_d.first_fatal = 1'b1;
      flags_d.fatal = 1'b1;
    end
    if (is_unc) begin
      if (flags_pre.unc) flags_d.multi_unc = 1'b1;
      else               unc_cap = 1'b1;
      flags_d.unc = 1'b1;
    end

    src_cor_d = cor_cap ? msg_src : src_cor_q;
    src_unc_d = unc_cap ? msg_src : src_unc_q;
    flags_en  = is_cor || is_unc || (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      src_cor_q <= '0;
      src_unc_q <= '0;
      vec_q     <= '0;
    end else begin
      if (flags_en) flags_q   <= flags_d;
      if (cor_cap)  src_cor_q <= src_cor_d;
      if (unc_cap)  src_unc_q <= src_unc_d;
      vec_q <= vec_in;
    end
  end
endmodule

// File: rtl/rec_cmd.sv
module rec_cmd
  import rec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_q,
  output logic [CMD_W-1:0] cmd_d
);
  always_comb cmd_d = cmd_wr ? cmd_wdata : cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_d;
  end
endmodule

// File: rtl/rec_irq.sv
module rec_irq
  import rec_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  sev_e             msg_sev,
  input  flags_t           flags_pre,
  input  flags_t           flags_d,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [CMD_W-1:0] cmd_d,
  input  logic             cmd_wr,
  input  logic             any_wr,
  input  logic             msi_en,
  input  logic             msix_en,
  input  logic [VEC_W-1:0] vec_q,
  output logic             intx_q,
  output logic             req_q,
  output logic             req_msix_q,
  output logic [VEC_W-1:0] req_vec_q
);
  logic             msg_mode, notify, wr_fire, req_d, intx_d;
  logic [CMD_W-1:0] active_old;

  always_comb begin
    msg_mode   = msi_en || msix_en;
    active_old = cond_map(flags_pre) & cmd_q;
    notify     = msg_valid && (|(sev_onehot(msg_sev) & cmd_q)) && (active_old == '0);
    wr_fire    = cmd_wr && (active_old == '0) && (|(cond_map(flags_pre) & cmd_d));
    req_d      = msg_mode && (notify || wr_fire);

    intx_d = intx_q;
    if (!msg_mode) begin
      if (any_wr)      intx_d = |(cond_map(flags_d) & cmd_d);
      else if (notify) intx_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intx_q     <= 1'b0;
      req_q      <= 1'b0;
      req_msix_q <= 1'b0;
      req_vec_q  <= '0;
    end else begin
      intx_q <= intx_d;
      req_q  <= req_d;
      if (req_d) begin
        req_msix_q <= msix_en;
        req_vec_q  <= vec_q;
      end
    end
  end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rec_pkg::*;
#(
  parameter int SRC_W       = 16,
  parameter int VEC_W       = 5,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               reg_wr_en,
  input  logic               reg_wr_addr,
  input  logic [REG_W-1:0]   reg_wr_data,
  input  logic [VEC_W-1:0]   irq_vec_in,
  input  logic               msi_en,
  input  logic               msix_en,
  output logic [REG_W-1:0]   root_status,
  output logic [CMD_W-1:0]   root_cmd,
  output logic [2*SRC_W-1:0] root_src_id,
  output logic               intx_level,
  output logic               irq_req,
  output logic               irq_req_msix,
  output logic [VEC_W-1:0]   irq_req_vec
);
  localparam int VEC_LSB = REG_W - VEC_W;

  logic             rst_core_n;
  logic             cmd_wr, sts_wr;
  flags_t           clr_mask, flags_q, flags_pre, flags_d;
  logic [SRC_W-1:0] src_cor_q, src_unc_q;
  logic [VEC_W-1:0] vec_q;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  sev_e             sev;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^reg_wr_data[REG_W-1:FLAG_W];

  rec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  always_comb begin
    sev      = sev_e'(msg_sev);
    cmd_wr   = reg_wr_en && !reg_wr_addr;
    sts_wr   = reg_wr_en &&  reg_wr_addr;
    clr_mask = sts_wr ? flags_t'(reg_wr_data[FLAG_W-1:0]) : flags_t'('0);
  end

  rec_status #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_status (
    .clk(clk), .rst_n(rst_core_n),
    .msg_valid(msg_valid), .msg_sev(sev), .msg_src(msg_src),
    .clr_mask(clr_mask), .vec_in(irq_vec_in),
    .flags_q(flags_q), .flags_pre(flags_pre), .flags_d(flags_d),
    .src_cor_q(src_cor_q), .src_unc_q(src_unc_q), .vec_q(vec_q)
  );

  rec_cmd u_cmd (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_wr(cmd_wr), .cmd_wdata(reg_wr_data[CMD_W-1:0]),
    .cmd_q(cmd_q), .cmd_d(cmd_d)
  );

  rec_irq #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_core_n),
    .msg_valid(msg_valid), .msg_sev(sev),
    .flags_pre(flags_pre), .flags_d(flags_d),
    .cmd_q(cmd_q), .cmd_d(cmd_d), .cmd_wr(cmd_wr), .any_wr(reg_wr_en),
    .msi_en(msi_en), .msix_en(msix_en), .vec_q(vec_q),
    .intx_q(intx_level), .req_q(irq_req),
    .req_msix_q(irq_req_msix), .req_vec_q(irq_req_vec)
  );

  always_comb begin
    root_status                      = '0;
    root_status[FLAG_W-1:0]          = flags_q;
    root_status[REG_W-1:VEC_LSB]     = vec_q;
    root_cmd                         = cmd_q;
    root_src_id                      = {src_unc_q, src_cor_q};
  end
endmodule

// File: rtl/rec_checker.sv
module rec_checker #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5,
  parameter int REG_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic [1:0]         msg_sev,
  input logic               reg_wr_en,
  input logic               reg_wr_addr,
  input logic [REG_W-1:0]   reg_wr_data,
  input logic [VEC_W-1:0]   irq_vec_in,
  input logic               msi_en,
  input logic               msix_en,
  input logic [REG_W-1:0]   root_status,
  input logic [2:0]         root_cmd,
  input logic [2*SRC_W-1:0] root_src_id,
  input logic               intx_level,
  input logic               irq_req
);
  localparam int VEC_LSB = REG_W - VEC_W;

  AST_COR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0) |=> root_status[0]); // R2

  AST_COR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0 && root_status[0] &&
     !(reg_wr_en && reg_wr_addr && reg_wr_data[0]))
    |=> $stable(root_src_id[SRC_W-1:0])); // R2

  AST_FIRST_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd2 && !root_status[2]) |=> root_status[4]); // R3

  AST_VEC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (root_status[REG_W-1:VEC_LSB] == $past(irq_vec_in))); // R6

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_addr) |=> (root_cmd == $past(reg_wr_data[2:0]))); // R7

  AST_NO_REQ_LEVEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_en || msix_en) |=> !irq_req); // R11

  AST_LEVEL_HELD_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en || msix_en) |=> $stable(intx_level)); // R11
endmodule

bind root_err_collector rec_checker #(.SRC_W(SRC_W), .VEC_W(VEC_W), .REG_W(REG_W)) u_rec_checker (
  .clk(clk), .rst_n(rst_core_n),
  .msg_valid(msg_valid), .msg_sev(msg_sev),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
  .irq_vec_in(irq_vec_in), .msi_en(msi_en), .msix_en(msix_en),
  .root_status(root_status), .root_cmd(root_cmd), .root_src_id(root_src_id),
  .intx_level(intx_level), .irq_req(irq_req)
);

// File: tb/root_err_collector_bench.sv
`timescale 1ns/1ps
module root_err_collector_bench;
  logic        clk, rst_n;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic        reg_wr_en, reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic [4:0]  irq_vec_in;
  logic        msi_en, msix_en;
  logic [31:0] root_status;
  logic [2:0]  root_cmd;
  logic [31:0] root_src_id;
  logic        intx_level, irq_req, irq_req_msix;
  logic [4:0]  irq_req_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [6:0]  m_flags;
  logic [15:0] m_src_lo, m_src_hi;
  logic [2:0]  m_cmd;
  logic [4:0]  m_vec, m_rvec;
  logic        m_intx, m_req, m_rmsix;

  root_err_collector u_root_err_collector (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .irq_vec_in(irq_vec_in), .msi_en(msi_en), .msix_en(msix_en),
    .root_status(root_status), .root_cmd(root_cmd), .root_src_id(root_src_id),
    .intx_level(intx_level), .irq_req(irq_req),
    .irq_req_msix(irq_req_msix), .irq_req_vec(irq_req_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", name, act, exp);
    end
  endtask

  function automatic logic [2:0] cmap(input logic [6:0] f);
    return {f[6], f[5], f[0]};
  endfunction

  task automatic model_step();
    logic [6:0] s, nd;
    logic [2:0] cnew, en_pre, sev1h;
    logic notify, wfire, mm;
    s = m_flags;
    if (reg_wr_en && reg_wr_addr) s = s & ~reg_wr_data[6:0];
    nd = s;
    sev1h = (msg_sev == 2'd0) ? 3'b001 : (msg_sev == 2'd1) ? 3'b010 :
            (msg_sev == 2'd2) ? 3'b100 : 3'b000;
    if (msg_valid && msg_sev == 2'd0) begin
      if (s[0]) nd[1] = 1'b1; else m_src_lo = msg_src;
      nd[0] = 1'b1;
    end
    if (msg_valid && msg_sev == 2'd1) nd[5] = 1'b1;
    if (msg_valid && msg_sev == 2'd2) begin
      if (!s[2]) nd[4] = 1'b1;
      nd[6] = 1'b1;
    end
    if (msg_valid && (msg_sev == 2'd1 || msg_sev == 2'd2)) begin
      if (s[2]) nd[3] = 1'b1; else m_src_hi = msg_src;
      nd[2] = 1'b1;
    end
    en_pre = cmap(s) & m_cmd;
    notify = msg_valid && (|(sev1h & m_cmd)) && (en_pre == 3'b000);
    cnew   = (reg_wr_en && !reg_wr_addr) ? reg_wr_data[2:0] : m_cmd;
    wfire  = reg_wr_en && !reg_wr_addr && (en_pre == 3'b000) && (|(cmap(s) & cnew));
    mm     = msi_en || msix_en;
    m_req  = mm && (notify || wfire);
    if (m_req) begin
      m_rmsix = msix_en;
      m_rvec  = m_vec;
    end
    if (!mm) begin
      if (reg_wr_en)   m_intx = |(cmap(nd) & cnew);
      else if (notify) m_intx = 1'b1;
    end
    m_flags = nd;
    m_cmd   = cnew;
    m_vec   = irq_vec_in;
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R5/R6 status", root_status, {m_vec, 20'h0, m_flags});
    chk("R2/R4 source id", root_src_id, {m_src_hi, m_src_lo});
    chk("R7 command", {29'h0, root_cmd}, {29'h0, m_cmd});
    chk("R9 level line", {31'h0, intx_level}, {31'h0, m_intx});
    chk("R8/R10/R11 request", {31'h0, irq_req}, {31'h0, m_req});
    if (m_req) begin
      chk("R11 request mode flag", {31'h0, irq_req_msix}, {31'h0, m_rmsix});
      chk("R11 request vector", {27'h0, irq_req_vec}, {27'h0, m_rvec});
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic v, input logic [1:0] sev, input logic [15:0] src,
                      input logic we, input logic wa, input logic [31:0] wd);
    msg_valid = v; msg_sev = sev; msg_src = src;
    reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic wr_cmd(input logic [2:0] c);
    step(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, {29'h0, c});
  endtask

  task automatic wr_clr_all();
    step(1'b0, 2'd0, 16'h0, 1'b1, 1'b1, 32'h0000_007F);
  endtask

  task automatic send(input logic [1:0] sev, input logic [15:0] src);
    step(1'b1, sev, src, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (R1 run did not complete) actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    msg_valid = 1'b0; msg_sev = 2'd0; msg_src = 16'h0;
    reg_wr_en = 1'b0; reg_wr_addr = 1'b0; reg_wr_data = 32'h0;
    irq_vec_in = 5'd9; msi_en = 1'b0; msix_en = 1'b0;
    m_flags = '0; m_src_lo = '0; m_src_hi = '0; m_cmd = '0;
    m_vec = '0; m_rvec = '0; m_intx = 1'b0; m_req = 1'b0; m_rmsix = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_vec = irq_vec_in;

    // R1 reset state
    chk("R1 flags after reset", {25'h0, root_status[6:0]}, 32'h0);
    chk("R1 source after reset", root_src_id, 32'h0);
    chk("R1 command after reset", {29'h0, root_cmd}, 32'h0);
    chk("R1 level after reset", {31'h0, intx_level}, 32'h0);
    chk("R1 request after reset", {31'h0, irq_req}, 32'h0);

    // Level mode, all enables on
    wr_cmd(3'b111);
    send(2'd0, 16'h1111);
    chk("R2 first correctable capture", {16'h0, root_src_id[15:0]}, 32'h1111);
    chk("R9 message raises level", {31'h0, intx_level}, 32'h1);
    send(2'd0, 16'h2222);
    chk("R2 multiple correctable", {31'h0, root_status[1]}, 32'h1);
    chk("R2 source kept on repeat", {16'h0, root_src_id[15:0]}, 32'h1111);
    send(2'd2, 16'hAAAA);
    chk("R3 fatal and first fatal", {25'h0, root_status[6:0]}, 32'h57);
    chk("R4 first uncorrectable capture", {16'h0, root_src_id[31:16]}, 32'hAAAA);
    send(2'd1, 16'hBBBB);
    chk("R4 multiple uncorrectable kept source", {16'h0, root_src_id[31:16]}, 32'hAAAA);
    chk("R3 nonfatal set", {31'h0, root_status[5]}, 32'h1);

    // Clear collides with a new message; vector bits in data ignored
    step(1'b1, 2'd0, 16'h3333, 1'b1, 1'b1, 32'hF800_007F);
    chk("R5 clear then message wins", {25'h0, root_status[6:0]}, 32'h01);
    chk("R5 new first source after clear", {16'h0, root_src_id[15:0]}, 32'h3333);
    chk("R6 vector not writable", {27'h0, root_status[31:27]}, 32'd9);
    wr_cmd(3'b000);
    chk("R9 write drops level", {31'h0, intx_level}, 32'h0);
    wr_cmd(3'b001);
    chk("R9 write raises level", {31'h0, intx_level}, 32'h1);

    // Plain message-signaled mode
    msi_en = 1'b1;
    wr_clr_all();
    chk("R11 level held in message mode", {31'h0, intx_level}, 32'h1);
    wr_cmd(3'b000);
    send(2'd0, 16'h4444);
    chk("R8 disabled severity no request", {31'h0, irq_req}, 32'h0);
    wr_cmd(3'b001);
    chk("R10 command write edge request", {31'h0, irq_req}, 32'h1);
    chk("R11 plain mode flag", {31'h0, irq_req_msix}, 32'h0);
    chk("R11 request vector", {27'h0, irq_req_vec}, 32'd9);
    wr_cmd(3'b011);
    chk("R10 no request when already true", {31'h0, irq_req}, 32'h0);
    wr_clr_all();
    send(2'd0, 16'h5555);
    chk("R8 message request", {31'h0, irq_req}, 32'h1);
    send(2'd0, 16'h6666);
    chk("R8 no repeat request", {31'h0, irq_req}, 32'h0);

    // Extended mode takes priority
    msix_en = 1'b1;
    irq_vec_in = 5'd21;
    idle();
    wr_clr_all();
    wr_cmd(3'b010);
    send(2'd1, 16'h7777);
    chk("R11 extended mode flag", {31'h0, irq_req_msix}, 32'h1);
    chk("R11 extended vector", {27'h0, irq_req_vec}, 32'd21);
    step(1'b1, 2'd3, 16'h8888, 1'b0, 1'b0, 32'h0);
    chk("R2 code 3 ignored", {25'h0, root_status[6:0]}, 32'h24);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic v, we, wa;
      logic [1:0] sv;
      logic [31:0] wd;
      if (($urandom % 50) == 0) msi_en = $urandom % 2;
      if (($urandom % 50) == 0) msix_en = $urandom % 2;
      if (($urandom % 40) == 0) irq_vec_in = $urandom % 32;
      v  = ($urandom % 10) < 3;
      sv = $urandom % 3;
      we = ($urandom % 100) < 15;
      wa = $urandom % 2;
      wd = $urandom;
      step(v, sv, $urandom % 65536, we, wa, wd);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule